// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Activity Wake

This block receives asynchronous serial characters in 8N1 framing: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A baud-tick enable input sets the timing, and it pulses OVS times per bit period. The serial input first goes through a two-flop synchronizer. Falling and rising edges are then found by comparing each synchronized sample with the one before it.

A falling edge starts the start-bit check. The character goes ahead only if the line is still low half a bit later. Each data bit is sampled in the middle of its bit period. When the stop bit has been sampled, the byte is loaded into the data output and the receive interrupt flag is raised. A low stop bit sets the framing-error flag. A read strobe clears the interrupt flag.

Software can also put the receiver into a wake mode, but only while no character is being received. In wake mode, normal reception is held off and the block watches the line for activity. The first falling edge raises the receive interrupt and loads a dummy zero byte. The next rising edge ends wake mode by itself. That rising edge does not start a character. Start-bit search begins again only at the next falling edge.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_idle is 1, and rx_irq, wake_en, frame_err and rx_data (0x00) are all 0.
- R2: A character is received as a low start bit, eight data bits with bit 0 first, and a stop bit. When the stop bit has been sampled, rx_data holds the eight data bits (rx_data[0] is the first bit sent) and rx_irq is 1.
- R3: A low pulse shorter than half a bit period does not start a character. The line must still be low at the mid-start sample, so after such a pulse rx_irq stays 0 and rx_idle returns to 1.
- R4: If the stop bit samples low, frame_err becomes 1 when that character completes. A later character with a high stop bit sets frame_err back to 0.
- R5: A data_rd pulse clears rx_irq unless a new character or wake event sets rx_irq in the same cycle.
- R6: rx_idle is 0 from the detected start edge until the stop-bit sample, and 1 at all other times.
- R7: A wake_set pulse sets wake_en only while rx_idle is 1. A pulse that arrives during a character is ignored: wake_en stays 0 and the character completes normally.
- R8: While wake_en is 1, no character is received. rx_idle stays 1, and a line held low for many bit times produces no received byte.
- R9: A falling edge on rxd while wake_en is 1, and before any wake event, sets rx_irq and loads rx_data with 0x00.
- R10: After a wake event, wake_en stays 1 while the line is low. It clears at the first rising edge, including a rising edge that comes before a full character time has passed.
- R11: The rising edge that clears wake_en does not start a character. The next falling edge starts normal reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | Oversampling enable, OVS pulses per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| wake_set | input | 1 | One-cycle request to enter wake mode |
| data_rd | input | 1 | One-cycle read strobe that clears rx_irq |
| rx_data | output | 8 | Last received byte, or 0x00 after a wake event |
| rx_irq | output | 1 | Receive interrupt flag |
| wake_en | output | 1 | Wake mode active |
| rx_idle | output | 1 | High when no character is in progress |
| frame_err | output | 1 | The last completed character had a low stop bit |

## Verification
The hardest case to reach is the wake exit. The line has to fall while wake mode is armed, stay low well beyond a character time, and then rise. After that rise, the receiver must not treat the edge as the start of a character.

The bench drives this sequence directly. It holds rxd low for twelve bit times and reads the flag in the middle to clear it. It checks that no byte appears while the line is low, and that wake_en drops within a few cycles of the rise. It then waits more than a character time with the line high before sending a real byte.

A second wake cycle uses a short low pulse to exercise the early exit. A wake_set pulse sent partway through a character, forked alongside the serial stimulus, covers the request that must be ignored.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uwr_sync_edge.sv
module uwr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line_s,
  output logic line_fall,
  output logic line_rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // Shift the raw line through the synchronizer chain.
  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = rxd;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], rxd};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_s    = sync_q[STAGES-1];
  assign line_fall = prev_q & ~line_s;
  assign line_rise = ~prev_q & line_s;
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame
  import uwr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  input  logic              line_fall,
  input  logic              hold_off,
  output logic              done,
  output logic              stop_ok,
  output logic [DATA_W-1:0] shift,
  output logic              idle
);
  localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW   = $clog2(DATA_W + 1);
  localparam int HALF = OVS / 2;

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    done    = 1'b0;
    stop_ok = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (line_fall && !hold_off) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            if (!line_s) begin
              state_d = RX_DATA;
              bit_d   = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {line_s, sh_q[DATA_W-1:1]};
            if (bit_q == BW'(DATA_W - 1)) begin
              state_d = RX_STOP;
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            done    = 1'b1;
            stop_ok = line_s;
            cnt_d   = '0;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign shift = sh_q;
  assign idle  = (state_q == RX_IDLE);
endmodule

// File: rtl/uwr_wake.sv
module uwr_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_set,
  input  logic rx_idle,
  input  logic line_fall,
  input  logic line_rise,
  output logic wake_en,
  output logic wake_evt
);
  logic en_q, en_d;
  logic seen_q, seen_d;

  always_comb begin
    en_d     = en_q;
    seen_d   = seen_q;
    wake_evt = 1'b0;
    if (en_q) begin
      if (!seen_q && line_fall) begin
        seen_d   = 1'b1;
        wake_evt = 1'b1;
      end else if (seen_q && line_rise) begin
        en_d   = 1'b0;
        seen_d = 1'b0;
      end
    end else if (wake_set && rx_idle) begin
      en_d   = 1'b1;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      seen_q <= seen_d;
    end
  end

  assign wake_en = en_q;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       wake_set,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic       rx_irq,
  output logic       wake_en,
  output logic       rx_idle,
  output logic       frame_err
);
  localparam int DATA_W = 8;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              line_s, line_fall, line_rise;
  logic              char_done, stop_ok, wake_evt, hold_off;
  logic [DATA_W-1:0] shift;
  logic [DATA_W-1:0] data_q, data_d;
  logic              irq_q, irq_d, ferr_q, ferr_d;

  // Reset asserts asynchronously and is released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uwr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rxd       (rxd),
    .line_s    (line_s),
    .line_fall (line_fall),
    .line_rise (line_rise)
  );

  assign hold_off = wake_en | wake_set;

  uwr_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (baud_tick),
    .line_s    (line_s),
    .line_fall (line_fall),
    .hold_off  (hold_off),
    .done      (char_done),
    .stop_ok   (stop_ok),
    .shift     (shift),
    .idle      (rx_idle)
  );

  uwr_wake u_wake (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wake_set  (wake_set),
    .rx_idle   (rx_idle),
    .line_fall (line_fall),
    .line_rise (line_rise),
    .wake_en   (wake_en),
    .wake_evt  (wake_evt)
  );

  always_comb begin
    data_d = data_q;
    irq_d  = irq_q;
    ferr_d = ferr_q;
    if (char_done) begin
      data_d = shift;
      ferr_d = ~stop_ok;
    end else if (wake_evt) begin
      data_d = '0;
    end
    if (char_done || wake_evt) irq_d = 1'b1;
    else if (data_rd)          irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q <= '0;
      irq_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      irq_q  <= irq_d;
      ferr_q <= ferr_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_irq    = irq_q;
  assign frame_err = ferr_q;
endmodule

// File: rtl/uwr_checker.sv
module uwr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_set,
  input logic       data_rd,
  input logic       rx_idle,
  input logic       rx_irq,
  input logic       wake_en,
  input logic [7:0] rx_data,
  input logic       char_done,
  input logic       wake_evt,
  input logic       line_fall,
  input logic       line_rise
);
  a_r2_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_irq);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !char_done && !wake_evt) |=> !rx_irq);

  a_r7_set_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_en) |-> ($past(wake_set) && $past(rx_idle)));

  a_r8_idle_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |-> rx_idle);

  a_r9_event_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (rx_irq && rx_data == 8'h00));

  a_r9_event_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (wake_en && line_fall));

  a_r10_exit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_en) |-> $past(line_rise));
endmodule

bind uart_wake_rx uwr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wake_set  (wake_set),
  .data_rd   (data_rd),
  .rx_idle   (rx_idle),
  .rx_irq    (rx_irq),
  .wake_en   (wake_en),
  .rx_data   (rx_data),
  .char_done (char_done),
  .wake_evt  (wake_evt),
  .line_fall (line_fall),
  .line_rise (line_rise)
);

// File: tb/sim_uart_wake_rx.sv
`timescale 1ns/1ps
module sim_uart_wake_rx;
  localparam int OVS  = 8;
  localparam int BITC = OVS * 2;   // baud tick every other cycle

  logic       clk = 1'b0;
  logic       rst_n, baud_tick, rxd, wake_set, data_rd;
  logic [7:0] rx_data;
  logic       rx_irq, wake_en, rx_idle, frame_err;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done_flag = 0;

  always #2.5 clk = ~clk;

  uart_wake_rx #(.OVS(OVS)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .wake_set(wake_set), .data_rd(data_rd), .rx_data(rx_data),
    .rx_irq(rx_irq), .wake_en(wake_en), .rx_idle(rx_idle),
    .frame_err(frame_err)
  );

  initial begin
    baud_tick = 1'b0;
    forever @(negedge clk) baud_tick = ~baud_tick;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    rxd = 1'b0;
    wait_cyc(BITC);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_cyc(BITC);
    end
    rxd = stop_bit;
    wait_cyc(BITC);
    rxd = 1'b1;
  endtask

  task automatic pulse_rd();
    data_rd = 1'b1;
    wait_cyc(1);
    data_rd = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_set = 1'b1;
    wait_cyc(1);
    wake_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; wake_set = 1'b0; data_rd = 1'b0;
    wait_cyc(4);
    chk("R1 idle", rx_idle, 1);
    chk("R1 irq", rx_irq, 0);
    chk("R1 wake_en", wake_en, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 data", rx_data, 0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 idle after release", rx_idle, 1);

    // R2: sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1);
      wait_cyc(2);
      chk("R2 byte", rx_data, v);
      chk("R2 irq", rx_irq, 1);
      pulse_rd();
      chk("R5 irq cleared", rx_irq, 0);
      wait_cyc(4);
    end

    // R3: short glitch
    rxd = 1'b0; wait_cyc(OVS / 2); rxd = 1'b1;
    wait_cyc(BITC * 2);
    chk("R3 no irq", rx_irq, 0);
    chk("R3 idle", rx_idle, 1);

    // R4: low stop bit, then good character clears
    send_frame(8'h81, 1'b0);
    wait_cyc(2);
    chk("R4 frame_err set", frame_err, 1);
    chk("R4 data", rx_data, 8'h81);
    pulse_rd();
    wait_cyc(BITC);
    send_frame(8'h42, 1'b1);
    wait_cyc(2);
    chk("R4 frame_err cleared", frame_err, 0);
    pulse_rd();
    wait_cyc(4);

    // R6 and R7: busy flag and ignored wake request mid-character
    fork
      send_frame(8'h3C, 1'b1);
      begin
        wait_cyc(BITC * 3);
        chk("R6 busy mid-character", rx_idle, 0);
        pulse_wake();
        wait_cyc(1);
        chk("R7 request ignored", wake_en, 0);
      end
    join
    wait_cyc(2);
    chk("R7 character intact", rx_data, 8'h3C);
    chk("R6 idle after character", rx_idle, 1);
    pulse_rd();
    wait_cyc(4);

    // R8-R11: full wake cycle with a long low line
    pulse_wake();
    chk("R7 accepted while idle", wake_en, 1);
    rxd = 1'b0;
    wait_cyc(6);
    chk("R9 irq on fall", rx_irq, 1);
    chk("R9 dummy data", rx_data, 0);
    chk("R10 held while low", wake_en, 1);
    pulse_rd();
    chk("R5 wake irq cleared", rx_irq, 0);
    wait_cyc(BITC * 12);
    chk("R8 no character in wake", rx_irq, 0);
    chk("R8 idle in wake", rx_idle, 1);
    chk("R10 still held", wake_en, 1);
    rxd = 1'b1;
    wait_cyc(6);
    chk("R10 cleared on rise", wake_en, 0);
    wait_cyc(BITC * 12);
    chk("R11 rise starts nothing", rx_irq, 0);
    chk("R11 idle", rx_idle, 1);
    send_frame(8'h5A, 1'b1);
    wait_cyc(2);
    chk("R11 next fall receives", rx_data, 8'h5A);
    chk("R11 irq", rx_irq, 1);
    pulse_rd();
    wait_cyc(4);

    // R10: early rise ends wake mode
    pulse_wake();
    rxd = 1'b0;
    wait_cyc(BITC * 3);
    rxd = 1'b1;
    wait_cyc(6);
    chk("R10 early rise exit", wake_en, 0);
    chk("R9 irq early case", rx_irq, 1);
    pulse_rd();
    wait_cyc(BITC * 12);
    chk("R11 idle after early exit", rx_irq, 0);

    done_flag = 1;
    finish_run();
  end
endmodule